// File: doc/BRIEF.md
# Feature Lock Sequence Detector

This block watches the bytes that the processor writes to the video controller's register-select port and keeps a single lock flag. While the flag is clear, the enhanced register page and the extended bank-mapping register are unavailable. Software opens the lock with a specific byte sequence, which must be preceded by a two-byte synchronising preamble. Sending that same sequence without its final byte closes the lock again. The port decode is done upstream; this block sees only a write strobe and the data byte.

The block also holds the extended bank-mapping register. That register accepts writes only while the lock is open. It drives the low-bank placement, the low-bank page number and the register-page enable. When the lock closes, the register keeps its contents, so the register page can be neither selected nor deselected until the lock opens again.

Top module: `feat_lock_det`

## Requirements
- R1: After reset, lock_open_o is 0 and reg_page_on_o, low_bank_o and low_page_o are all 0.
- R2: The detector matches key bytes only after a sync preamble: a nonzero byte written immediately before a zero byte. Key bytes written without that preamble leave the lock unchanged.
- R3: After the preamble, the 15 strobed bytes FF,77,B3,51,A8,D4,62,39,9C,46,2B,15,8A,CD,EE set lock_open_o to 1. The new value is visible in the cycle after the EE write.
- R4: After the preamble, the 14 strobed bytes FF through CD followed by any byte other than EE (zero included) clear lock_open_o in the cycle after that byte.
- R5: A byte that differs from the expected key byte abandons the match. The rest of the key that follows does not change the lock.
- R6: A nonzero byte followed by a zero byte restarts matching from the first key byte at any point, including part-way through a key.
- R7: Cycles with wr_en_i low have no effect, whatever value is on wr_data_i.
- R8: Strobed traffic that does not complete a full key leaves lock_open_o unchanged.
- R9: While lock_open_o is 0, map_wr_i is ignored and the mapping outputs keep their values. This includes a map write issued in the same cycle as the EE write that opens the lock.
- R10: While lock_open_o is 1, a map_wr_i pulse loads the mapping register, and the outputs follow in the next cycle. map_data_i[2:0] sets low_page_o. map_data_i[4:3]=3 sets reg_page_on_o=1 and low_bank_o=0. Any other value of map_data_i[4:3] sets reg_page_on_o=0 and low_bank_o=map_data_i[4:3] (0: 0000h, 1: 4000h, 2: 8000h).
- R11: The preamble is exactly one nonzero-then-zero pair directly before FF. Several nonzero bytes before the zero are accepted. A second zero byte before FF breaks the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the watched port |
| wr_data_i | input | 8 | Byte written to the watched port |
| map_wr_i | input | 1 | Write strobe for the extended mapping register |
| map_data_i | input | 5 | Mapping value: [4:3] bank mode, [2:0] page |
| lock_open_o | output | 1 | Feature lock open flag |
| reg_page_on_o | output | 1 | Enhanced register page enabled |
| low_bank_o | output | 2 | Low-bank placement code |
| low_page_o | output | 3 | Low-bank page number |

## Verification
The assertions check, on every cycle, the following: the lock rises only right after a strobed EE and falls only right after some other strobed byte; idle cycles leave the lock flag and the match position unchanged; a sync pair always restarts the match at the first key byte; a wrong byte always drops the match. They also check that mapping writes are blocked while the lock is closed and loaded while it is open. Only the bench's scenarios can show whole-sequence effects. These are: opening through the complete key, closing through the truncated key, restarting part-way through a key, breaking the preamble with a doubled zero, and the same-cycle race between the opening byte and a map write. Long random byte streams are compared against a reference model.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned KEY_LEN = 15;
  localparam int unsigned IDX_W   = $clog2(KEY_LEN);
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned PAGE_W  = 3;
  localparam int unsigned MAP_W   = MODE_W + PAGE_W;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [PAGE_W-1:0] page;
  } map_cfg_t;

  function automatic logic [BYTE_W-1:0] key_byte(input logic [IDX_W-1:0] idx);
    logic [BYTE_W-1:0] b;
    case (idx)
      4'd0:    b = 8'hFF;
      4'd1:    b = 8'h77;
      4'd2:    b = 8'hB3;
      4'd3:    b = 8'h51;
      4'd4:    b = 8'hA8;
      4'd5:    b = 8'hD4;
      4'd6:    b = 8'h62;
      4'd7:    b = 8'h39;
      4'd8:    b = 8'h9C;
      4'd9:    b = 8'h46;
      4'd10:   b = 8'h2B;
      4'd11:   b = 8'h15;
      4'd12:   b = 8'h8A;
      4'd13:   b = 8'hCD;
      4'd14:   b = 8'hEE;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lock_sync_mon.sv
module lock_sync_mon
  import lock_det_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] data_i,
  output logic          sync_o
);
  logic prev_nz_q;

  // zero byte directly after a nonzero byte
  assign sync_o = wr_en_i && (data_i == '0) && prev_nz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_nz_q <= 1'b0;
    else if (wr_en_i) prev_nz_q <= (data_i != '0);
  end
endmodule

// File: rtl/lock_seq_match.sv
module lock_seq_match
  import lock_det_pkg::*;
#(
  parameter int unsigned DW  = BYTE_W,
  parameter int unsigned LEN = KEY_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] data_i,
  input  logic          sync_i,
  output logic          open_o,
  output logic          close_o
);
  localparam int unsigned IW = $clog2(LEN);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic          in_seq_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] exp_byte;
  logic          match, at_last;

  assign exp_byte = DW'(key_byte(IDX_W'(idx_q)));
  assign match    = (data_i == exp_byte);
  assign at_last  = (idx_q == LAST);

  assign open_o  = wr_en_i && in_seq_q && at_last && match;
  assign close_o = wr_en_i && in_seq_q && at_last && !match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_seq_q <= 1'b0;
      idx_q    <= '0;
    end else if (wr_en_i) begin
      if (sync_i) begin
        in_seq_q <= 1'b1;
        idx_q    <= '0;
      end else if (in_seq_q && !at_last && match) begin
        idx_q    <= idx_q + 1'b1;
      end else begin
        in_seq_q <= 1'b0;
        idx_q    <= '0;
      end
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(idx_q) && $stable(in_seq_q)));
  // R2
  no_sync_no_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !in_seq_q && !sync_i) |=> !in_seq_q);
  // R5
  miss_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_seq_q && !sync_i && (data_i != exp_byte)) |=> !in_seq_q);
  // R6
  resync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sync_i) |=> (in_seq_q && idx_q == '0));
endmodule

// File: rtl/lock_map_reg.sv
module lock_map_reg
  import lock_det_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              wr_i,
  input  logic [MAP_W-1:0]  data_i,
  output logic              reg_page_on_o,
  output logic [MODE_W-1:0] low_bank_o,
  output logic [PAGE_W-1:0] low_page_o
);
  map_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cfg_q <= '0;
    else if (wr_i && lock_i)  cfg_q <= map_cfg_t'(data_i);
  end

  // mode all-ones: register page on, bank back at base 0
  assign reg_page_on_o = &cfg_q.mode;
  assign low_bank_o    = reg_page_on_o ? '0 : cfg_q.mode;
  assign low_page_o    = cfg_q.page;

  // R9
  closed_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && wr_i) |=> $stable(cfg_q));
  // R10
  open_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && wr_i) |=> (cfg_q == $past(data_i)));
endmodule

// File: rtl/feat_lock_det.sv
module feat_lock_det
  import lock_det_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              map_wr_i,
  input  logic [MAP_W-1:0]  map_data_i,
  output logic              lock_open_o,
  output logic              reg_page_on_o,
  output logic [MODE_W-1:0] low_bank_o,
  output logic [PAGE_W-1:0] low_page_o
);
  logic sync, open_hit, close_hit, lock_q;

  lock_sync_mon #(.DW(BYTE_W)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .data_i  (wr_data_i),
    .sync_o  (sync)
  );

  lock_seq_match #(.DW(BYTE_W), .LEN(KEY_LEN)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .data_i  (wr_data_i),
    .sync_i  (sync),
    .open_o  (open_hit),
    .close_o (close_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= 1'b0;
    else if (open_hit)  lock_q <= 1'b1;
    else if (close_hit) lock_q <= 1'b0;
  end

  assign lock_open_o = lock_q;

  lock_map_reg u_map (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lock_i        (lock_q),
    .wr_i          (map_wr_i),
    .data_i        (map_data_i),
    .reg_page_on_o (reg_page_on_o),
    .low_bank_o    (low_bank_o),
    .low_page_o    (low_page_o)
  );

  // R3
  open_after_ee_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_open_o) |-> ($past(wr_en_i) && $past(wr_data_i) == 8'hEE));
  // R4
  close_after_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_open_o) |-> ($past(wr_en_i) && $past(wr_data_i) != 8'hEE));
  // R7
  lock_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(lock_open_o));
endmodule

// File: tb/feat_lock_det_tb.sv
module feat_lock_det_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       map_wr = 1'b0;
  logic [4:0] map_data = 5'h00;
  logic       lock_open, pg_on;
  logic [1:0] bank;
  logic [2:0] page;

  int n_chk = 0;
  int n_err = 0;

  localparam logic [7:0] KEY [15] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8,
    8'hD4, 8'h62, 8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};

  // reference model state
  logic       m_prev = 1'b0, m_seq = 1'b0, m_lock = 1'b0;
  int         m_idx = 0;
  logic [1:0] m_mode = 2'd0;
  logic [2:0] m_page = 3'd0;

  always #5 clk = ~clk;

  feat_lock_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .map_wr_i(map_wr), .map_data_i(map_data), .lock_open_o(lock_open),
    .reg_page_on_o(pg_on), .low_bank_o(bank), .low_page_o(page)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_out();
    logic       on = (m_mode == 2'd3);
    logic [1:0] bk = on ? 2'd0 : m_mode;
    return {1'b0, m_lock, on, bk, m_page};
  endfunction

  function automatic logic [7:0] dut_out();
    return {1'b0, lock_open, pg_on, bank, page};
  endfunction

  task automatic model_upd(input logic w, input logic [7:0] b, input logic mw, input logic [4:0] md);
    logic sy;
    if (mw && m_lock) begin
      m_mode = md[4:3];
      m_page = md[2:0];
    end
    if (w) begin
      sy = (b == 8'h00) && m_prev;
      if (m_seq && m_idx == 14) m_lock = (b == 8'hEE);
      if (sy) begin
        m_seq = 1'b1; m_idx = 0;
      end else if (m_seq && m_idx < 14 && b == KEY[m_idx]) begin
        m_idx++;
      end else begin
        m_seq = 1'b0; m_idx = 0;
      end
      m_prev = (b != 8'h00);
    end
  endtask

  // inputs are driven and released at negedges
  task automatic step(input logic w, input logic [7:0] b, input logic mw, input logic [4:0] md);
    wr_en = w; wr_data = b; map_wr = mw; map_data = md;
    model_upd(w, b, mw, md);
    @(negedge clk);
    wr_en = 1'b0; map_wr = 1'b0;
    wr_data = 8'($urandom); map_data = 5'($urandom);
  endtask

  task automatic wb(input logic [7:0] b);
    step(1'b1, b, 1'b0, 5'd0);
  endtask

  task automatic key_part(input int n);
    for (int i = 0; i < n; i++) wb(KEY[i]);
  endtask

  task automatic open_lock();
    wb(8'h3C); wb(8'h00); key_part(15);
  endtask

  task automatic close_lock();
    wb(8'h3C); wb(8'h00); key_part(14); wb(8'h5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset", dut_out(), 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", dut_out(), 8'h00);

    // R2: key without preamble
    key_part(15);
    chk("R2 no preamble", {7'd0, lock_open}, 8'd0);

    // R3: full key opens, not before the EE
    wb(8'h21); wb(8'h00); key_part(14);
    chk("R3 before EE", {7'd0, lock_open}, 8'd0);
    wb(8'hEE);
    chk("R3 opened", {7'd0, lock_open}, 8'd1);

    // R10: map writes while open
    step(1'b0, 8'h00, 1'b1, 5'b11_101);
    chk("R10 page on", {4'd0, pg_on, bank, 1'b0}, 8'b0000_1000);
    chk("R10 page num", {5'd0, page}, 8'd5);
    step(1'b0, 8'h00, 1'b1, 5'b10_010);
    chk("R10 bank 8000", {4'd0, pg_on, bank, 1'b0}, 8'b0000_0100);
    chk("R10 page num 2", {5'd0, page}, 8'd2);

    // R8: unrelated traffic incl. sync pairs keeps lock open
    wb(8'h00); wb(8'hFF); wb(8'h77); wb(8'h00); wb(8'h55); wb(8'h01); wb(8'h00); wb(8'hFF);
    chk("R8 stays open", {7'd0, lock_open}, 8'd1);

    // R4: truncated key closes
    close_lock();
    chk("R4 closed", {7'd0, lock_open}, 8'd0);

    // R9: map write while closed ignored
    step(1'b0, 8'h00, 1'b1, 5'b01_111);
    chk("R9 ignored", dut_out(), {1'b0, 1'b0, 1'b0, 2'd2, 3'd2});

    // R7: key on bus without strobe does not advance
    wb(8'h11); wb(8'h00);
    for (int i = 0; i < 15; i++) step(1'b0, KEY[i], 1'b0, 5'd0);
    chk("R7 no strobe", {7'd0, lock_open}, 8'd0);
    key_part(15);
    chk("R7 match position held", {7'd0, lock_open}, 8'd1);

    // R4 with zero terminator
    wb(8'h11); wb(8'h00); key_part(14); wb(8'h00);
    chk("R4 zero terminator", {7'd0, lock_open}, 8'd0);

    // R5: mismatch mid key
    wb(8'h11); wb(8'h00); key_part(3); wb(8'h99);
    for (int i = 3; i < 15; i++) wb(KEY[i]);
    chk("R5 mismatch", {7'd0, lock_open}, 8'd0);

    // R6: resync part-way
    wb(8'h11); wb(8'h00); key_part(5); wb(8'h40); wb(8'h00); key_part(15);
    chk("R6 resync", {7'd0, lock_open}, 8'd1);
    close_lock();
    chk("R6 relock", {7'd0, lock_open}, 8'd0);

    // R11: doubled zero breaks, multiple nonzeros fine
    wb(8'h07); wb(8'h00); wb(8'h00); key_part(15);
    chk("R11 double zero", {7'd0, lock_open}, 8'd0);
    wb(8'h03); wb(8'h04); wb(8'h05); wb(8'h00); key_part(15);
    chk("R11 multi nonzero", {7'd0, lock_open}, 8'd1);
    close_lock();

    // R9: map write in same cycle as opening EE is ignored
    wb(8'h22); wb(8'h00); key_part(14);
    step(1'b1, 8'hEE, 1'b1, 5'b00_001);
    chk("R9 same cycle", dut_out(), {1'b0, 1'b1, 1'b0, 2'd2, 3'd2});
    chk("R9 model agrees", dut_out(), model_out());

    // random bursts against model
    for (int t = 0; t < 500; t++) begin
      int k = $urandom_range(0, 15);
      if ($urandom_range(0, 3) != 0) begin
        wb(8'($urandom_range(1, 255))); wb(8'h00);
      end
      for (int i = 0; i < k; i++) begin
        logic [7:0] b = (i == 14 && $urandom_range(0, 1) == 0) ? 8'($urandom) : KEY[i];
        if ($urandom_range(0, 20) == 0) b = 8'($urandom);
        step(1'b1, b, ($urandom_range(0, 5) == 0), 5'($urandom));
        if ($urandom_range(0, 3) == 0)
          step(1'b0, 8'($urandom), ($urandom_range(0, 3) == 0), 5'($urandom));
      end
      chk("R8 random vs model", dut_out(), model_out());
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule